// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that runs a list of up to sixteen serial transfers without help from the processor. Each list slot has three parts. A transmit word is shifted out on MOSI, most significant bit first. A receive word is filled from MISO. A command byte picks the chip-select pattern for the slot, the frame width, an optional extra pause, and whether the selects stay low into the next slot. Software loads the slots and the control registers, then sets the enable bit last. The controller then walks from the start slot to the end slot.

When the end slot is done, the controller either goes back to slot 0 or stops and raises a finished flag. The pointer register can be rewritten while the list is running. Such a write waits in a shadow copy and takes over only when the current transfer is complete, so a running list can be redirected without cutting a frame in half. A low level on the slave-select input while the master is running is a mode fault. A mode fault stops the controller at once and sets a sticky flag.

Register map, word addressed: 0x00 format register, 0x01 run register, 0x02 pointer register, 0x03 pause register, 0x04 status register. The receive words are at 0x10 to 0x1F and are read only. The transmit words are at 0x20 to 0x2F. The command bytes are at 0x30 to 0x3F, in the low eight bits.

Top module: `qspi_master`

## Requirements
- R1: After reset, pcs_n is 4'hF and sck is low. The status register (0x04), the run register (0x01) and the pointer register (0x02) all read 0.
- R2: Setting run bit 15 (0x01) starts the list at the start slot, pointer register bits [3:0], and ends it at the end slot, bits [11:8]. Slots are taken in ascending order. With wrap bit 15 clear, the controller stops after the end slot. It then clears the run bit and sets finished, status bit 7. Status bits [3:0] give the last completed slot.
- R3: Frames go out and come in MSB first. When command bit 6 is set, the width comes from format bits [13:10]: 0 means 16 bits, 1 to 7 mean 8 bits, and 8 to 15 mean that many bits. When command bit 6 is clear, the width is 8 bits. The received word is stored right-aligned with the upper bits zero. Format bit 15 is the idle clock level. Format bit 14 selects sampling on the trailing edge (1) or the leading edge (0), and data changes on the other edge.
- R4: During a slot, pcs_n equals command bits [3:0]. If command bit 7 (continue) is set, the selects stay at that value until the next slot starts. Otherwise pcs_n returns to 4'hF for at least one clock before the next slot. pcs_n is 4'hF whenever the controller is not running.
- R5: When command bit 5 is set, the pause between the end of that slot and the start of the next grows by the value of pause register bits [7:0], counted in clocks.
- R6: With wrap set, the slot after the end slot is slot 0, and the list never finishes on its own.
- R7: A write to the pointer register while running has no effect and is not visible on readback until the current transfer completes. After that, the new start and end slots apply, and execution continues at the new start slot.
- R8: While running, writing the value already held to the run register or the format register changes nothing in the slot order or the frame data.
- R9: A low ss_n while running clears the run bit, forces pcs_n to 4'hF and sck to its idle level within one clock, sets fault, status bit 6, and stops all further frames.
- R10: A status flag is cleared only by reading it while it is set and then writing 0 to that bit. A 0 written without that prior read leaves the flag set.
- R11: Each SCK half-period lasts format bits [7:0] clocks. A value of 0 holds SCK at its idle level and no bits move.
- R12: While pcs_n is 4'hF, sck equals format bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 6 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs_n | output | 4 | Peripheral chip selects, active low |
| ss_n | input | 1 | Slave-select input; low while running is a mode fault |

## Verification
The assertions assume that register writes are single-cycle strobes and that ss_n is a clean synchronous level. They also assume that software starts the list only from a stopped state, so the shadow pointer copy is empty whenever the controller becomes idle. The stimulus programs the pointer register directly only while stopped. It sends redirecting writes only in the middle of a frame. It pulses ss_n low for a single clock well inside a transfer. It changes the format register only while stopped, or rewrites it with an identical value.

// File: rtl/qspi_master.sv
module qspi_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  pcs_n,
  input  logic        ss_n
);
  localparam logic [5:0] A_FMT = 6'h00, A_RUN = 6'h01, A_PTR = 6'h02,
                         A_PAU = 6'h03, A_STA = 6'h04;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_PAUSE, S_DONE} st_t;
  st_t st;

  logic        cpol, cpha, en, pend, fin, mf, fin_arm, mf_arm;
  logic [3:0]  wsel, endp_a, newp_a, endp_h, newp_h, last, ptr, pcs_q;
  logic        wrap_a, wrap_h, ccont, cdly, sck_t;
  logic [7:0]  baud, dt, hcnt, dcnt;
  logic [15:0] shreg, rxsh;
  logic [4:0]  nb;
  logic [5:0]  ecnt;
  logic [15:0] rxm [16];
  logic [15:0] txm [16];
  logic [7:0]  cmdm [16];

  function automatic logic [4:0] width_of(input logic use_fmt, input logic [3:0] w);
    if (!use_fmt) return 5'd8;
    if (w == 4'd0) return 5'd16;
    if (w < 4'd8) return 5'd8;
    return {1'b0, w};
  endfunction

  wire [4:0] wf_next   = width_of(cmdm[ptr][6], wsel);
  wire       fault     = en && !ss_n;
  wire       stop_req  = wr_en && addr == A_RUN && !wdata[15];
  wire       start_req = wr_en && addr == A_RUN && wdata[15];
  wire       lead      = ~ecnt[0];
  wire       samp_edge = cpha ? ~lead : lead;
  wire       shft_edge = cpha ? (lead && ecnt != 6'd0) : ~lead;
  wire [5:0] last_edge = {nb, 1'b0} - 6'd1;
  wire       eng_done  = en && !fault && !stop_req && st == S_DONE;

  assign sck   = cpol ^ sck_t;
  assign mosi  = shreg[15];
  assign pcs_n = pcs_q;

  always_comb begin
    rdata = 16'h0000;
    case (addr[5:4])
      2'd0: case (addr)
        A_FMT: rdata = {cpol, cpha, wsel, 2'b00, baud};
        A_RUN: rdata = {en, 15'h0000};
        A_PTR: rdata = {wrap_a, 3'b000, endp_a, 4'h0, newp_a};
        A_PAU: rdata = {8'h00, dt};
        A_STA: rdata = {8'h00, fin, mf, 2'b00, last};
        default: rdata = 16'h0000;
      endcase
      2'd1: rdata = rxm[addr[3:0]];
      2'd2: rdata = txm[addr[3:0]];
      default: rdata = {8'h00, cmdm[addr[3:0]]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr[5:4] == 2'd2) txm[addr[3:0]] <= wdata;
    if (wr_en && addr[5:4] == 2'd3) cmdm[addr[3:0]] <= wdata[7:0];
    if (eng_done) rxm[ptr] <= rxsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cpol <= 1'b0; cpha <= 1'b0; wsel <= 4'd0; baud <= 8'd0;
      en <= 1'b0; pend <= 1'b0; fin <= 1'b0; mf <= 1'b0; fin_arm <= 1'b0; mf_arm <= 1'b0;
      wrap_a <= 1'b0; endp_a <= 4'd0; newp_a <= 4'd0;
      wrap_h <= 1'b0; endp_h <= 4'd0; newp_h <= 4'd0;
      dt <= 8'd0; last <= 4'd0; ptr <= 4'd0; pcs_q <= 4'hF;
      ccont <= 1'b0; cdly <= 1'b0; sck_t <= 1'b0; hcnt <= 8'd0; dcnt <= 8'd0;
      shreg <= 16'h0000; rxsh <= 16'h0000; nb <= 5'd8; ecnt <= 6'd0;
    end else begin
      if (rd_en && addr == A_STA) begin fin_arm <= fin; mf_arm <= mf; end
      if (wr_en && addr == A_STA) begin
        if (fin_arm && !wdata[7]) begin fin <= 1'b0; fin_arm <= 1'b0; end
        if (mf_arm && !wdata[6]) begin mf <= 1'b0; mf_arm <= 1'b0; end
      end
      if (wr_en && addr == A_FMT) begin
        {cpol, cpha, wsel} <= wdata[15:10];
        baud <= wdata[7:0];
      end
      if (wr_en && addr == A_PAU) dt <= wdata[7:0];

      if (fault || (en && stop_req)) begin
        if (fault) begin mf <= 1'b1; mf_arm <= 1'b0; end
        en <= 1'b0; st <= S_IDLE; pcs_q <= 4'hF; sck_t <= 1'b0;
        if (pend) begin
          {wrap_a, endp_a, newp_a} <= {wrap_h, endp_h, newp_h};
          pend <= 1'b0;
        end
      end else if (!en) begin
        if (start_req) begin
          en <= 1'b1; st <= S_SETUP;
          if (pend) begin
            {wrap_a, endp_a, newp_a} <= {wrap_h, endp_h, newp_h};
            ptr <= newp_h; pend <= 1'b0;
          end else ptr <= newp_a;
        end
      end else begin
        case (st)
          S_SETUP: begin
            pcs_q <= cmdm[ptr][3:0];
            ccont <= cmdm[ptr][7];
            cdly  <= cmdm[ptr][5];
            nb    <= wf_next;
            shreg <= txm[ptr] << (5'd16 - wf_next);
            rxsh  <= 16'h0000;
            ecnt  <= 6'd0; hcnt <= 8'd0; sck_t <= 1'b0;
            st    <= S_SHIFT;
          end
          S_SHIFT: if (baud != 8'd0) begin
            if (hcnt == baud - 8'd1) begin
              hcnt  <= 8'd0;
              sck_t <= ~sck_t;
              ecnt  <= ecnt + 6'd1;
              if (samp_edge) rxsh <= {rxsh[14:0], miso};
              if (shft_edge) shreg <= {shreg[14:0], 1'b0};
              if (ecnt == last_edge) begin
                st   <= S_PAUSE;
                dcnt <= cdly ? dt : 8'd0;
              end
            end else hcnt <= hcnt + 8'd1;
          end
          S_PAUSE: if (dcnt == 8'd0) st <= S_DONE; else dcnt <= dcnt - 8'd1;
          S_DONE: begin
            last <= ptr;
            if (!ccont) pcs_q <= 4'hF;
            if (pend) begin
              {wrap_a, endp_a, newp_a} <= {wrap_h, endp_h, newp_h};
              ptr <= newp_h; pend <= 1'b0; st <= S_SETUP;
            end else if (ptr == endp_a) begin
              if (wrap_a) begin
                ptr <= 4'd0; st <= S_SETUP;
              end else begin
                fin <= 1'b1; fin_arm <= 1'b0; en <= 1'b0;
                pcs_q <= 4'hF; st <= S_IDLE;
              end
            end else begin
              ptr <= ptr + 4'd1; st <= S_SETUP;
            end
          end
          default: st <= S_IDLE;
        endcase
      end

      if (wr_en && addr == A_PTR) begin
        if (en) begin
          {wrap_h, endp_h, newp_h} <= {wdata[15], wdata[11:8], wdata[3:0]};
          pend <= 1'b1;
        end else begin
          {wrap_a, endp_a, newp_a} <= {wdata[15], wdata[11:8], wdata[3:0]};
        end
      end
    end
  end

  AST_CS_IDLE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pcs_n == 4'hF); // R4
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_SHIFT |-> sck == cpol); // R12
  AST_FIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> !en); // R2
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf) |-> (!en && pcs_n == 4'hF)); // R9
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st != S_DONE) |=> (!en || $stable({wrap_a, endp_a, newp_a}))); // R7
endmodule

// File: tb/test_qspi_master.sv
module test_qspi_master;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, miso = 1'b0, ss_n = 1'b1;
  logic [5:0] addr = 6'h00;
  logic [15:0] wdata = 16'h0000, rdata;
  logic sck, mosi;
  logic [3:0] pcs_n;

  qspi_master i_qspi_master (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .pcs_n(pcs_n), .ss_n(ss_n));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // behavioural slave and per-clock reference state
  logic s_cpol = 1'b0, s_cpha = 1'b0;
  int s_nb = 8, bidx = 0, ecnt_s = 0, nfr = 0, cyc = 0, last_t = 0, first_t = 0;
  int cur_gap = 0, cur_half = 0;
  bit cs_idle = 1'b1, cur_cs = 1'b1;
  logic prev_sck = 1'b0;
  logic [15:0] rxacc = 16'h0;
  logic [15:0] fr_data [64];
  logic [3:0]  fr_cs   [64];
  int          fr_gap  [64];
  int          fr_half [64];
  bit          fr_csg  [64];

  function automatic logic [15:0] mask(input int nb);
    return (nb >= 16) ? 16'hFFFF : ((16'h1 << nb) - 16'h1);
  endfunction
  function automatic logic [15:0] sw(input int k, input int nb);
    return (16'h5A00 ^ (16'(k) * 16'h0123)) & mask(nb);
  endfunction
  function automatic logic [15:0] txv(input int e);
    return 16'h3C00 + 16'(e) * 16'h0011;
  endfunction
  function automatic logic [3:0] csv(input int e);
    return 4'hF ^ (4'h1 << (e % 4));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished && pcs_n == 4'hF) check("R12 sck idle", {31'b0, sck}, {31'b0, s_cpol});
    if (pcs_n == 4'hF) begin
      bidx = 0; ecnt_s = 0; cs_idle = 1'b1;
    end else if (sck !== prev_sck) begin
      bit ld, smp;
      ld = (sck !== s_cpol);
      if (ecnt_s == 0) begin cur_gap = cyc - last_t; first_t = cyc; cur_cs = cs_idle; cs_idle = 1'b0; end
      if (ecnt_s == 1) cur_half = cyc - first_t;
      last_t = cyc;
      ecnt_s++;
      smp = s_cpha ? !ld : ld;
      if (smp) begin
        rxacc = {rxacc[14:0], mosi};
        bidx++;
        if (bidx == s_nb) begin
          if (nfr < 64) begin
            fr_data[nfr] = rxacc & mask(s_nb); fr_cs[nfr] = pcs_n;
            fr_gap[nfr] = cur_gap; fr_half[nfr] = cur_half; fr_csg[nfr] = cur_cs;
          end
          nfr++;
          bidx = 0;
        end
      end
      if (ecnt_s == 2 * s_nb) ecnt_s = 0;
    end
    prev_sck = sck;
    begin
      logic [15:0] w;
      w = sw(nfr, s_nb);
      miso = (bidx < s_nb) ? w[s_nb - 1 - bidx] : 1'b0;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(posedge clk); #2;
    rd_en = 1'b1; addr = a;
    #3 d = rdata;
    @(posedge clk); #2;
    rd_en = 1'b0;
  endtask

  task automatic set_fmt(input logic [15:0] d, input int nb);
    wr(6'h00, d);
    s_cpol = d[15]; s_cpha = d[14]; s_nb = nb;
  endtask

  task automatic wait_stop;
    logic [15:0] v;
    int n;
    n = 0;
    v = 16'h8000;
    while (v[15] && n < 20000) begin rd(6'h01, v); n++; end
    if (v[15]) check("watchdog stop", 1, 0);
  endtask

  task automatic wait_frames(input int k);
    int n;
    n = 0;
    while (nfr < k && n < 20000) begin @(posedge clk); n++; end
    if (nfr < k) check("watchdog frames", nfr, k);
  endtask

  initial begin
    #1_500_000;
    check("watchdog expired", 1, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 pcs_n", pcs_n, 4'hF);
    check("R1 sck", sck, 1'b0);
    rd(6'h04, v); check("R1 status", v, 16'h0000);
    rd(6'h01, v); check("R1 run", v, 16'h0000);
    rd(6'h02, v); check("R1 pointer", v, 16'h0000);

    for (int i = 0; i < 16; i++) wr(6'h20 + 6'(i), txv(i));

    // A: basic queue 0..3, 8-bit, mode 0, continue and pause
    set_fmt(16'h2002, 8);
    wr(6'h03, 16'd5);
    wr(6'h02, 16'h0300);
    wr(6'h30, {8'h00, 4'hC, csv(0)});
    wr(6'h31, {8'h00, 4'h6, csv(1)});
    wr(6'h32, {8'h00, 4'h4, csv(2)});
    wr(6'h33, {8'h00, 4'h4, csv(3)});
    nfr = 0;
    wr(6'h01, 16'h8000);
    wait_stop();
    check("R2 frame count", nfr, 4);
    for (int k = 0; k < 4; k++) begin
      check("R3 tx data", fr_data[k], txv(k) & 16'h00FF);
      check("R4 cs pattern", fr_cs[k], csv(k));
      check("R11 half period", fr_half[k], 2);
      rd(6'h10 + 6'(k), v); check("R3 rx stored", v, sw(k, 8));
    end
    check("R4 continue held", fr_csg[1], 0);
    check("R4 released between", fr_csg[2], 1);
    check("R5 pause length", fr_gap[2] - fr_gap[1], 5);
    @(negedge clk); check("R4 idle cs", pcs_n, 4'hF);
    wr(6'h04, 16'h0000);
    rd(6'h04, v); check("R10 fin kept without read", v, 16'h0083);
    check("R2 finished last", v, 16'h0083);
    wr(6'h04, 16'h0000);
    rd(6'h04, v); check("R10 fin cleared", v, 16'h0003);

    // B: 12-bit, idle-high, trailing sample, same-value writes
    set_fmt(16'hF003, 12);
    for (int e = 2; e < 5; e++) wr(6'h30 + 6'(e), {8'h00, 4'h4, csv(e)});
    wr(6'h02, 16'h0402);
    nfr = 0;
    wr(6'h01, 16'h8000);
    wait_frames(1);
    wr(6'h01, 16'h8000);
    wr(6'h00, 16'hF003);
    wait_stop();
    check("R8 frame count", nfr, 3);
    for (int k = 0; k < 3; k++) begin
      check("R3 12-bit data", fr_data[k], txv(k + 2) & 16'h0FFF);
      check("R8 order", fr_cs[k], csv(k + 2));
      check("R11 half period 3", fr_half[k], 3);
      rd(6'h12 + 6'(k), v); check("R3 12-bit rx", v, sw(k, 12));
    end

    // C: wrap from 14 through end slot 1, command width bit clear
    set_fmt(16'h4001, 8);
    for (int e = 0; e < 16; e++) wr(6'h30 + 6'(e), {8'h00, 4'h0, csv(e)});
    wr(6'h04, 16'h0000);
    rd(6'h04, v);
    wr(6'h04, 16'h0000);
    wr(6'h02, 16'h810E);
    nfr = 0;
    wr(6'h01, 16'h8000);
    wait_frames(6);
    wr(6'h01, 16'h0000);
    repeat (3) @(posedge clk);
    begin
      int ord [6] = '{14, 15, 0, 1, 0, 1};
      for (int k = 0; k < 6; k++) check("R6 wrap order", fr_data[k], txv(ord[k]) & 16'h00FF);
    end
    rd(6'h04, v); check("R6 no finish", v[7], 1'b0);
    @(negedge clk); check("R4 stopped cs", pcs_n, 4'hF);

    // D: buffered pointer rewrite mid-frame, 16-bit
    set_fmt(16'h0002, 16);
    for (int e = 0; e < 16; e++) wr(6'h30 + 6'(e), {8'h00, 4'h4, csv(e)});
    wr(6'h02, 16'h0700);
    nfr = 0;
    wr(6'h01, 16'h8000);
    while (!(nfr == 1 && bidx >= 2)) @(posedge clk);
    wr(6'h02, 16'h0B0A);
    rd(6'h02, v); check("R7 held readback", v, 16'h0700);
    wait_stop();
    check("R7 frame count", nfr, 4);
    begin
      int ord [4] = '{0, 1, 10, 11};
      for (int k = 0; k < 4; k++) check("R7 redirect order", fr_data[k], txv(ord[k]));
    end
    rd(6'h1A, v); check("R3 16-bit rx", v, sw(2, 16));
    rd(6'h02, v); check("R7 applied readback", v, 16'h0B0A);
    rd(6'h04, v); check("R7 last slot", v[3:0], 4'd11);

    // E: mode fault
    set_fmt(16'h2002, 8);
    wr(6'h02, 16'h0700);
    nfr = 0;
    wr(6'h01, 16'h8000);
    wait_frames(1);
    @(posedge clk); #2 ss_n = 1'b0;
    @(posedge clk); #2 ss_n = 1'b1;
    @(negedge clk);
    check("R9 cs forced", pcs_n, 4'hF);
    check("R9 sck idle", sck, 1'b0);
    rd(6'h01, v); check("R9 run cleared", v, 16'h0000);
    begin
      int k0;
      k0 = nfr;
      repeat (150) @(posedge clk);
      check("R9 no more frames", nfr, k0);
    end
    wr(6'h04, 16'h0000);
    rd(6'h04, v); check("R10 fault kept without read", v[6], 1'b1);
    check("R9 fault flag", v[6], 1'b1);
    wr(6'h04, 16'h0000);
    rd(6'h04, v); check("R10 fault cleared", v[6], 1'b0);

    // F: divisor 0 holds the clock
    set_fmt(16'h2000, 8);
    wr(6'h02, 16'h0000);
    nfr = 0;
    wr(6'h01, 16'h8000);
    repeat (200) @(posedge clk);
    @(negedge clk);
    check("R11 no clock sck", sck, 1'b0);
    check("R11 no frames", nfr, 0);
    rd(6'h01, v); check("R11 still running", v, 16'h8000);
    wr(6'h01, 16'h0000);
    @(negedge clk); check("R4 cs after stop", pcs_n, 4'hF);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule